// File: doc/BRIEF.md
# Fixed-Latency Wide-Word Slot Scheduler

This block executes wide instruction words. Each word carries six operation slots, and each slot has a fixed function. The slot's position alone selects the unit that runs it. The two lowest slots go to integer units, the next two to memory units and the top two to floating-point units. Every unit class has a constant latency. The block carries each result down a delay pipeline of exactly that many stages, then drives it on the write-back port that belongs to the slot. In that same cycle it commits the result to the register file.

The block performs no dependency checks, has no interlocks and never stalls. The code generator must keep producers and consumers far enough apart. Source registers are read when a word is accepted. A consumer issued too early therefore sees the old value, and that is the intended behaviour. The unit models are small stand-ins: an immediate load, an add and a pass-through.

The input side is a valid/ready stream. Ready is low only while reset is held, so there is never back-pressure once reset is released. The write-back ports carry a valid strobe and have no ready, because a fixed-latency pipeline cannot hold a result back.

Top module: `vliw_sched_top`

## Requirements
- R1: `iw_ready` is 0 while `rst_n` is low and 1 on every cycle after the first clock edge following reset release; a word is accepted on every edge where `iw_valid` and `iw_ready` are both 1.
- R2: Slots 0 and 1 (integer) present their write-back on `wb_valid`/`wb_idx`/`wb_data` of the same slot index between edge n and edge n+1, for a word accepted at edge n.
- R3: Slots 2 and 3 (memory) present their write-back between edge n+2 and edge n+3.
- R4: Slots 4 and 5 (floating point) present their write-back between edge n+3 and edge n+4.
- R5: A slot whose opcode is 0, and every slot of a cycle without an accepted word, produces no write-back.
- R6: Slot i of the word always retires on write-back port i, with the latency of its position, whatever its opcode.
- R7: Slot i sits at `iw_word[24*i +: 24]` with opcode [23:16], destination [15:10], source A [9:5] and source B [4:0]. If opcode bit 1 is set, the result is the 10-bit value {A,B} zero-extended. Otherwise, if opcode bit 0 is set, the result is reg[A]+reg[B]. Otherwise the result is reg[A].
- R8: Sources are read when the word is accepted. A result due at edge n+L is visible to words accepted at edge n+L or later, and words accepted earlier (including the same word) read the previous value.
- R9: When several write-backs target one register in the same cycle, the register keeps the value of the highest-numbered slot.
- R10: Reset clears all write-back valids and sets all 64 registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iw_valid | input | 1 | Instruction word present |
| iw_ready | output | 1 | Block can accept a word |
| iw_word | input | 144 | Six 24-bit slot fields, slot 0 lowest |
| wb_valid | output | 6 | Per-slot write-back strobe |
| wb_idx | output | 36 | Per-slot destination register, 6 bits each |
| wb_data | output | 192 | Per-slot result, 32 bits each |

## Verification
The first pattern is words with all six slots live, issued back to back. This separates the three latency classes and shows whether any slot is routed to the wrong port. The second pattern is a long-latency producer followed by consumers at growing distances, which finds the exact cycle at which a result becomes readable and confirms that earlier consumers read the old value. The third pattern is same-register collisions, both within one word and across words whose latencies line up; these expose the write priority. The last pattern is NOP slots and idle cycles, which must leave every port quiet.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int SLOTS  = 6;
  localparam int OPC_W  = 8;
  localparam int DST_W  = 6;
  localparam int SRC_W  = 5;
  localparam int SLOT_W = OPC_W + DST_W + 2 * SRC_W;
  localparam int WORD_W = SLOTS * SLOT_W;
  localparam int OPB_ADD = 0;
  localparam int OPB_IMM = 1;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [DST_W-1:0] dst;
    logic [SRC_W-1:0] sa;
    logic [SRC_W-1:0] sb;
  } slot_t;

  typedef enum logic [1:0] {UC_INT, UC_MEM, UC_FP} ucls_t;

  function automatic ucls_t slot_class(input int s);
    if (s < 2) return UC_INT;
    if (s < 4) return UC_MEM;
    return UC_FP;
  endfunction

  function automatic int slot_lat(input int s, input int li, input int lm, input int lf);
    case (slot_class(s))
      UC_INT:  return li;
      UC_MEM:  return lm;
      default: return lf;
    endcase
  endfunction
endpackage

// File: rtl/vliw_unit.sv
module vliw_unit
  import vliw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  slot_t             op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    if (op.opc[OPB_IMM])
      result = DATA_W'({op.sa, op.sb});
    else if (op.opc[OPB_ADD])
      result = opnd_a + opnd_b;
    else
      result = opnd_a;
  end
endmodule

// File: rtl/vliw_delay.sv
module vliw_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic [DEPTH-1:0]        v_q;
  logic [DEPTH-1:0][W-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      v_q[0] <= in_v;
      d_q[0] <= in_d;
      for (int k = 1; k < DEPTH; k++) begin
        v_q[k] <= v_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  assign out_v = v_q[DEPTH-1];
  assign out_d = d_q[DEPTH-1];
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  parameter int NRD    = 12,
  parameter int NWR    = 6,
  parameter int IDX_W  = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NWR-1:0]               wr_en,
  input  logic [NWR-1:0][IDX_W-1:0]    wr_idx,
  input  logic [NWR-1:0][DATA_W-1:0]   wr_data,
  input  logic [NRD-1:0][IDX_W-1:0]    rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else begin
      for (int w = 0; w < NWR; w++)
        if (wr_en[w]) mem[wr_idx[w]] <= wr_data[w];
    end
  end

  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      rd_data[p] = mem[rd_idx[p]];
      for (int w = 0; w < NWR; w++)
        if (wr_en[w] && wr_idx[w] == rd_idx[p]) rd_data[p] = wr_data[w];
    end
  end
endmodule

// File: rtl/vliw_sched_top.sv
module vliw_sched_top
  import vliw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NREG    = 64,
  parameter int INT_LAT = 1,
  parameter int MEM_LAT = 3,
  parameter int FP_LAT  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iw_valid,
  output logic                     iw_ready,
  input  logic [WORD_W-1:0]        iw_word,
  output logic [SLOTS-1:0]         wb_valid,
  output logic [SLOTS*DST_W-1:0]   wb_idx,
  output logic [SLOTS*DST_W*0+SLOTS*DATA_W-1:0] wb_data
);
  localparam int IDX_W = DST_W;
  localparam int NRD   = 2 * SLOTS;
  localparam int PW    = IDX_W + DATA_W;

  logic ready_q;
  logic accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign iw_ready = ready_q;
  assign accept   = iw_valid & ready_q;

  logic [NRD-1:0][IDX_W-1:0]    rd_idx;
  logic [NRD-1:0][DATA_W-1:0]   rd_data;
  logic [SLOTS-1:0]             wv;
  logic [SLOTS-1:0][IDX_W-1:0]  wi;
  logic [SLOTS-1:0][DATA_W-1:0] wd;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int LAT = slot_lat(s, INT_LAT, MEM_LAT, FP_LAT);
    slot_t             fld;
    logic [DATA_W-1:0] res;
    logic              issue_v;
    logic [PW-1:0]     pipe_out;

    assign fld           = iw_word[s*SLOT_W +: SLOT_W];
    assign rd_idx[2*s]   = IDX_W'(fld.sa);
    assign rd_idx[2*s+1] = IDX_W'(fld.sb);
    assign issue_v       = accept && (fld.opc != '0);

    vliw_unit #(.DATA_W(DATA_W)) u_unit (
      .op     (fld),
      .opnd_a (rd_data[2*s]),
      .opnd_b (rd_data[2*s+1]),
      .result (res)
    );

    vliw_delay #(.W(PW), .DEPTH(LAT)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (issue_v),
      .in_d  ({fld.dst, res}),
      .out_v (wv[s]),
      .out_d (pipe_out)
    );

    assign wi[s] = pipe_out[PW-1 -: IDX_W];
    assign wd[s] = pipe_out[DATA_W-1:0];
    assign wb_valid[s]                 = wv[s];
    assign wb_idx[s*DST_W +: DST_W]    = wi[s];
    assign wb_data[s*DATA_W +: DATA_W] = wd[s];
  end

  vliw_regfile #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .NRD    (NRD),
    .NWR    (SLOTS),
    .IDX_W  (IDX_W)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wv),
    .wr_idx  (wi),
    .wr_data (wd),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/vliw_sched_chk.sv
module vliw_sched_chk
  import vliw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INT_LAT = 1,
  parameter int MEM_LAT = 3,
  parameter int FP_LAT  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     iw_valid,
  input logic                     iw_ready,
  input logic [WORD_W-1:0]        iw_word,
  input logic [SLOTS-1:0]         wb_valid,
  input logic [SLOTS*DST_W-1:0]   wb_idx,
  input logic [SLOTS*DATA_W-1:0]  wb_data
);
  logic acc;
  assign acc = iw_valid && iw_ready;

  function automatic logic [OPC_W-1:0] opc_of(input logic [WORD_W-1:0] w, input int s);
    return w[s*SLOT_W + 2*SRC_W + DST_W +: OPC_W];
  endfunction
  function automatic logic [DST_W-1:0] dst_of(input logic [WORD_W-1:0] w, input int s);
    return w[s*SLOT_W + 2*SRC_W +: DST_W];
  endfunction

  // R1: ready stays up once out of reset
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> iw_ready);

  if (INT_LAT == 1) begin : g_int
    // R2: integer slot retires on the next cycle with its destination
    p_int_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && opc_of(iw_word, 0) != '0) |=> (wb_valid[0] && wb_idx[DST_W-1:0] == $past(dst_of(iw_word, 0))));
    // R5: a NOP in an integer slot gives no write-back
    p_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && opc_of(iw_word, 1) == '0) |=> !wb_valid[1]);
    // R5: an idle cycle leaves the integer ports quiet
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> (wb_valid[1:0] == 2'b00));
  end

  if (MEM_LAT == 3) begin : g_mem
    // R3: a memory write-back traces back to a live slot three cycles ago
    p_mem_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid[2] |-> ($past(acc, 3) && $past(opc_of(iw_word, 2), 3) != '0));
  end

  if (FP_LAT == 4) begin : g_fp
    // R4: floating-point write-back traces back four cycles
    p_fp_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid[5] |-> ($past(acc, 4) && $past(opc_of(iw_word, 5), 4) != '0));
    // R6: slot 5 retires on port 5 with its own destination
    p_fp_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid[5] |-> (wb_idx[5*DST_W +: DST_W] == $past(dst_of(iw_word, 5), 4)));
  end
endmodule

bind vliw_sched_top vliw_sched_chk #(
  .DATA_W  (DATA_W),
  .INT_LAT (INT_LAT),
  .MEM_LAT (MEM_LAT),
  .FP_LAT  (FP_LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iw_valid (iw_valid),
  .iw_ready (iw_ready),
  .iw_word  (iw_word),
  .wb_valid (wb_valid),
  .wb_idx   (wb_idx),
  .wb_data  (wb_data)
);

// File: tb/tb_vliw_sched_top.sv
module tb_vliw_sched_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         iw_valid = 1'b0;
  logic         iw_ready;
  logic [143:0] iw_word = '0;
  logic [5:0]   wb_valid;
  logic [35:0]  wb_idx;
  logic [191:0] wb_data;

  always #4 clk = ~clk;

  vliw_sched_top dut (
    .clk(clk), .rst_n(rst_n), .iw_valid(iw_valid), .iw_ready(iw_ready),
    .iw_word(iw_word), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  typedef struct {
    int          due;
    int          slot;
    logic [5:0]  idx;
    logic [31:0] data;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mdl [64];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  string       cur = "R10";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lat_of(input int s);
    return (s < 2) ? 1 : (s < 4) ? 3 : 4;
  endfunction

  function automatic logic [23:0] mk(input logic [7:0] o, input logic [5:0] d,
                                     input logic [4:0] a, input logic [4:0] b);
    return {o, d, a, b};
  endfunction

  function automatic logic [23:0] imm(input logic [5:0] d, input logic [9:0] v);
    return mk(8'h02, d, v[9:5], v[4:0]);
  endfunction

  function automatic logic [143:0] w6(input logic [23:0] s0, s1, s2, s3, s4, s5);
    return {s5, s4, s3, s2, s1, s0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compare due items, then commit them to the model in slot order
  task automatic monitor_check();
    exp_t nq[$];
    for (int s = 0; s < 6; s++) begin
      bit   found = 0;
      exp_t e;
      foreach (q[k]) if (q[k].due == cyc && q[k].slot == s) begin found = 1; e = q[k]; end
      chk(wb_valid[s] === found, cur, 64'(wb_valid[s]), 64'(found));
      if (found) begin
        chk(wb_idx[s*6 +: 6] === e.idx, cur, 64'(wb_idx[s*6 +: 6]), 64'(e.idx));
        chk(wb_data[s*32 +: 32] === e.data, cur, 64'(wb_data[s*32 +: 32]), 64'(e.data));
      end
    end
    for (int s = 0; s < 6; s++)
      foreach (q[k]) if (q[k].due == cyc && q[k].slot == s) mdl[q[k].idx] = q[k].data;
    foreach (q[k]) if (q[k].due != cyc) nq.push_back(q[k]);
    q = nq;
  endtask

  // driver: present one word (or idle) and push its expected write-backs
  task automatic step(input logic v, input logic [143:0] w);
    @(negedge clk);
    monitor_check();
    iw_valid = v;
    iw_word  = w;
    if (v) begin
      for (int s = 0; s < 6; s++) begin
        logic [23:0] f = w[s*24 +: 24];
        exp_t e;
        if (f[23:16] != 8'h00) begin
          e.due  = cyc + lat_of(s);
          e.slot = s;
          e.idx  = f[15:10];
          if (f[17])      e.data = 32'(f[9:0]);
          else if (f[16]) e.data = mdl[f[9:5]] + mdl[f[4:0]];
          else            e.data = mdl[f[9:5]];
          q.push_back(e);
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  initial begin
    for (int r = 0; r < 64; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    // R10 / R1: reset state
    chk(iw_ready === 1'b0, "R1", 64'(iw_ready), 64'd0);
    chk(wb_valid === 6'd0, "R10", 64'(wb_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(iw_ready === 1'b1, "R1", 64'(iw_ready), 64'd1);

    // R10: registers start at zero
    cur = "R10";
    step(1'b1, w6(mk(8'h04, 6'd31, 5'd30, 5'd0), mk(8'h01, 6'd29, 5'd7, 5'd9), '0, '0, '0, '0));
    idle(5);

    // R6 / R2 / R3 / R4: all slots live, back to back
    cur = "R6";
    step(1'b1, w6(imm(1, 10'h011), imm(2, 10'h022), imm(3, 10'h033),
                  imm(4, 10'h044), imm(5, 10'h055), imm(45, 10'h3ff)));
    step(1'b1, w6(imm(6, 10'h066), imm(7, 10'h077), mk(8'h01, 6'd8, 5'd1, 5'd2),
                  mk(8'h04, 6'd9, 5'd1, 5'd0), imm(12, 10'h12c), imm(13, 10'h0d1)));
    idle(5);

    // R7: the three unit functions on seeded registers
    cur = "R7";
    step(1'b1, w6(mk(8'h01, 6'd14, 5'd3, 5'd4), mk(8'h04, 6'd15, 5'd5, 5'd9),
                  mk(8'h03, 6'd16, 5'd1, 5'd2), mk(8'h81, 6'd17, 5'd8, 5'd12),
                  mk(8'h08, 6'd18, 5'd13, 5'd1), mk(8'h05, 6'd19, 5'd12, 5'd13)));
    idle(5);

    // R8: stale reads before latency expires, same word reads old value
    cur = "R8";
    step(1'b1, w6(mk(8'h04, 6'd22, 5'd10, 5'd0), '0, '0, '0, '0, imm(10, 10'h2aa)));
    for (int d = 1; d <= 5; d++)
      step(1'b1, w6(mk(8'h04, 6'(22 + d), 5'd10, 5'd0), '0, '0, '0, '0, '0));
    step(1'b1, w6(imm(11, 10'h005), mk(8'h01, 6'd28, 5'd11, 5'd11), '0, '0, '0, '0));
    step(1'b1, w6(mk(8'h01, 6'd27, 5'd11, 5'd11), '0, '0, '0, '0, '0));
    idle(5);

    // R9: collisions in one word and across aligned latencies
    cur = "R9";
    step(1'b1, w6(imm(20, 10'h001), imm(20, 10'h002), '0, '0, '0, '0));
    idle(1);
    step(1'b1, w6(mk(8'h04, 6'd24, 5'd20, 5'd0), '0, imm(21, 10'h005), '0, '0, '0));
    idle(1);
    step(1'b1, w6('0, imm(21, 10'h009), '0, '0, '0, '0));
    idle(2);
    step(1'b1, w6(mk(8'h04, 6'd25, 5'd21, 5'd0), mk(8'h04, 6'd26, 5'd20, 5'd0), '0, '0, '0, '0));
    idle(5);

    // R5: NOP slots and idle cycles stay quiet
    cur = "R5";
    step(1'b1, '0);
    step(1'b1, w6('0, imm(2, 10'h100), '0, '0, '0, '0));
    step(1'b0, w6(imm(3, 10'h1), imm(3, 10'h1), imm(3, 10'h1), imm(3, 10'h1), imm(3, 10'h1), imm(3, 10'h1)));
    step(1'b1, w6('0, '0, '0, mk(8'h04, 6'd30, 5'd3, 5'd0), '0, '0));
    idle(6);

    // R1: ready stays high through traffic
    chk(iw_ready === 1'b1, "R1", 64'(iw_ready), 64'd1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule